// File: doc/BRIEF.md
# Word-to-Byte Bus Bridge

This block joins a 16-bit processor data bus to a region of 8-bit peripherals. When the processor reads a word from that region, the bridge pulls its ready line low and runs two back-to-back byte cycles on the narrow bus. The byte from the even address goes first and the byte from the odd address second. The bridge then packs the two bytes big-endian into one word and lets the processor continue. A word write is cut into two byte writes in the same order, again behind a stall. Word accesses are always word aligned, so the bridge does not look at bit 0 of the processor address.

A single region-select input tells the bridge whether the current access targets the narrow region. When it does not, the access goes straight through with no stall. Read data then comes from the wide-bus return path, and the narrow bus stays quiet. Each byte cycle has a fixed length of `BYTE_CYC` clock cycles, so a region access always holds the processor for a known number of cycles.

Top module: `wide_narrow_bridge`

## Requirements
- R1: While reset is high, and in the first cycle after it, `cpu_ready` is 1 and both `nb_rd` and `nb_wr` are 0. A reset that arrives during a transfer abandons that transfer.
- R2: For a read in the region, `cpu_ready` is 0 in the cycle the strobe is first seen and stays 0 for 2*BYTE_CYC+1 cycles in total. It is 1 in the cycle after that.
- R3: For each region access, the first narrow cycle uses the address with bit 0 cleared and the second uses bit 0 set. The upper address bits are copied from the processor. Each byte strobe is held for exactly BYTE_CYC cycles.
- R4: For a region read, `cpu_rdata[15:8]` holds the byte from the even address and `cpu_rdata[7:0]` holds the byte from the odd address, valid once `cpu_ready` returns to 1.
- R5: Processor address bit 0 has no effect on a word access. A read from an odd address returns the same word as a read from the even address below it.
- R6: A region write puts `cpu_wdata[15:8]` on the even address and then `cpu_wdata[7:0]` on the odd address, with the same 2*BYTE_CYC+1 cycle stall as a read.
- R7: An access with `region_sel` at 0 never lowers `cpu_ready` and never raises `nb_rd` or `nb_wr`. On reads, `cpu_rdata` equals `wide_rdata`.
- R8: `nb_rd` and `nb_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | ADDR_W | Processor byte address; bit 0 is ignored |
| cpu_rd | input | 1 | Processor read strobe, held until ready |
| cpu_wr | input | 1 | Processor write strobe, held until ready |
| cpu_wdata | input | 16 | Processor write word |
| region_sel | input | 1 | 1 when the access targets the narrow region |
| wide_rdata | input | 16 | Read data from the wide bus for accesses outside the region |
| nb_rdata | input | 8 | Read byte from the narrow bus |
| cpu_ready | output | 1 | 0 while the processor must wait |
| cpu_rdata | output | 16 | Read word returned to the processor |
| nb_addr | output | ADDR_W | Narrow bus byte address |
| nb_rd | output | 1 | Narrow bus read strobe |
| nb_wr | output | 1 | Narrow bus write strobe |
| nb_wdata | output | 8 | Narrow bus write byte |

## Verification
The bench builds the bridge with ADDR_W at 16 and BYTE_CYC at 3. This makes the byte-phase counter count across several cycles, so the stall is 7 cycles, and an off-by-one in the phase length or in the point where the byte is captured changes both the measured stall and the returned word. A byte-addressed model of the peripheral reacts to the narrow strobes. The bench compares each access against its own copy of that memory. The test set covers even and odd addresses, reads straight after writes, accesses that pass through outside the region, and a reset in the middle of a transfer.

// File: rtl/wnb_pkg.sv
package wnb_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_EVEN,
        SEQ_ODD,
        SEQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic busy;      // a narrow byte cycle is in progress
        logic is_wr;     // the current transfer is a write
        logic odd_lane;  // second (odd-address) byte
        logic lane_end;  // last clock of the current byte cycle
    } lane_op_t;

    function automatic logic [WORD_W-1:0] join_be(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic [BYTE_W-1:0] pick_lane(input logic [WORD_W-1:0] w,
                                                    input logic odd);
        return odd ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/wnb_phase_timer.sv
module wnb_phase_timer #(
    parameter int BYTE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (BYTE_CYC > 1) ? $clog2(BYTE_CYC) : 1;

    generate
        if (BYTE_CYC == 1) begin : g_single
            assign last = run;
        end else begin : g_count
            logic [CNT_W-1:0] count;
            assign last = run && (count == CNT_W'(BYTE_CYC - 1));
            always_ff @(posedge clk) begin
                if (rst || !run || last) count <= '0;
                else                     count <= count + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/wnb_sequencer.sv
module wnb_sequencer
    import wnb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_wr,
    input  logic       lane_end,
    output seq_state_t state,
    output lane_op_t   op
);
    seq_state_t nxt;
    logic       wr_q;

    always_comb begin
        nxt = state;
        case (state)
            SEQ_IDLE: if (start)    nxt = SEQ_EVEN;
            SEQ_EVEN: if (lane_end) nxt = SEQ_ODD;
            SEQ_ODD:  if (lane_end) nxt = SEQ_DONE;
            default:                nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            wr_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == SEQ_IDLE && start) wr_q <= start_wr;
        end
    end

    always_comb begin
        op.busy     = (state == SEQ_EVEN) || (state == SEQ_ODD);
        op.is_wr    = wr_q;
        op.odd_lane = (state == SEQ_ODD);
        op.lane_end = lane_end && op.busy;
    end
endmodule

// File: rtl/wnb_word_assembler.sv
module wnb_word_assembler
    import wnb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_op_t          op,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word_out
);
    logic [BYTE_W-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (op.busy && !op.is_wr && op.lane_end) begin
            if (op.odd_lane) lo_q <= byte_in;
            else             hi_q <= byte_in;
        end
    end

    assign word_out = join_be(hi_q, lo_q);
endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge
    import wnb_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BYTE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [15:0]       cpu_wdata,
    input  logic              region_sel,
    input  logic [15:0]       wide_rdata,
    input  logic [7:0]        nb_rdata,
    output logic              cpu_ready,
    output logic [15:0]       cpu_rdata,
    output logic [ADDR_W-1:0] nb_addr,
    output logic              nb_rd,
    output logic              nb_wr,
    output logic [7:0]        nb_wdata
);
    seq_state_t        state;
    lane_op_t          op;
    logic              req, start, lane_end;
    logic [WORD_W-1:0] packed_word;
    logic              unused_bit0;

    assign unused_bit0 = cpu_addr[0];
    assign req   = region_sel && (cpu_rd || cpu_wr);
    assign start = req && (state == SEQ_IDLE);

    wnb_phase_timer #(.BYTE_CYC(BYTE_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (op.busy),
        .last (lane_end)
    );

    wnb_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_wr (cpu_wr),
        .lane_end (lane_end),
        .state    (state),
        .op       (op)
    );

    wnb_word_assembler u_asm (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .byte_in  (nb_rdata),
        .word_out (packed_word)
    );

    assign cpu_ready = !((state == SEQ_IDLE && req) || op.busy);
    assign cpu_rdata = region_sel ? packed_word : wide_rdata;
    assign nb_addr   = {cpu_addr[ADDR_W-1:1], op.odd_lane};
    assign nb_rd     = op.busy && !op.is_wr;
    assign nb_wr     = op.busy && op.is_wr;
    assign nb_wdata  = pick_lane(cpu_wdata, op.odd_lane);
endmodule

// File: rtl/wide_narrow_bridge_chk.sv
module wide_narrow_bridge_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              region_sel,
    input logic [15:0]       cpu_wdata,
    input logic              cpu_ready,
    input logic [ADDR_W-1:0] nb_addr,
    input logic              nb_rd,
    input logic              nb_wr,
    input logic [7:0]        nb_wdata
);
    // R8
    nb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nb_rd && nb_wr));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (nb_rd || nb_wr) |-> !cpu_ready);

    // R3
    first_even_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(nb_rd) || $rose(nb_wr)) |-> !nb_addr[0]);

    // R3
    lane_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((nb_rd || nb_wr) && ($past(nb_rd) || $past(nb_wr)) &&
         (nb_addr[0] != $past(nb_addr[0])))
        |-> (nb_addr[0] && !$past(nb_addr[0])));

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        ((cpu_rd || cpu_wr) && !region_sel && $past(cpu_ready))
        |-> (cpu_ready && !nb_rd && !nb_wr));

    // R6
    wr_high_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (nb_wr && !nb_addr[0]) |-> (nb_wdata == cpu_wdata[15:8]));

    // R6
    wr_low_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (nb_wr && nb_addr[0]) |-> (nb_wdata == cpu_wdata[7:0]));
endmodule

bind wide_narrow_bridge wide_narrow_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .region_sel (region_sel),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .nb_addr    (nb_addr),
    .nb_rd      (nb_rd),
    .nb_wr      (nb_wr),
    .nb_wdata   (nb_wdata)
);

// File: tb/sim_wide_narrow_bridge.sv
module sim_wide_narrow_bridge;
    localparam int AW        = 16;
    localparam int BC        = 3;
    localparam int EXP_STALL = 2 * BC + 1;
    localparam int NVEC      = 8;

    // {wr, sel, addr[15:0], wdata[15:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 16'h0010, 16'h0000},
        {1'b0, 1'b1, 16'h0023, 16'h0000},
        {1'b1, 1'b1, 16'h0040, 16'hA55A},
        {1'b0, 1'b1, 16'h0041, 16'h0000},
        {1'b0, 1'b0, 16'h0100, 16'h0000},
        {1'b1, 1'b0, 16'h0102, 16'hBEEF},
        {1'b1, 1'b1, 16'h00FE, 16'h1234},
        {1'b0, 1'b1, 16'h00FF, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] cpu_addr;
    logic          cpu_rd, cpu_wr, region_sel;
    logic [15:0]   cpu_wdata, wide_rdata;
    logic [7:0]    nb_rdata;
    logic          cpu_ready;
    logic [15:0]   cpu_rdata;
    logic [AW-1:0] nb_addr;
    logic          nb_rd, nb_wr;
    logic [7:0]    nb_wdata;

    always #5 clk = ~clk;

    wide_narrow_bridge #(.ADDR_W(AW), .BYTE_CYC(BC)) u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .region_sel(region_sel),
        .wide_rdata(wide_rdata), .nb_rdata(nb_rdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .nb_addr(nb_addr), .nb_rd(nb_rd),
        .nb_wr(nb_wr), .nb_wdata(nb_wdata)
    );

    // Narrow peripheral model
    logic [7:0] mem [256];
    logic [7:0] shadow [256];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
        end else if (nb_wr) begin
            mem[nb_addr[7:0]] <= nb_wdata;
        end
    end
    assign nb_rdata = mem[nb_addr[7:0]];

    // Narrow bus activity monitor
    int cyc_even, cyc_odd, first_lane, both_cnt;
    initial begin
        cyc_even = 0; cyc_odd = 0; first_lane = -1; both_cnt = 0;
    end
    always @(posedge clk) begin
        if (nb_rd || nb_wr) begin
            if (first_lane < 0) first_lane = int'(nb_addr[0]);
            if (nb_addr[0]) cyc_odd++;
            else            cyc_even++;
        end
        if (nb_rd && nb_wr) both_cnt++;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input bit sel, input logic [15:0] a,
                          input logic [15:0] wd, output int stall,
                          output logic [15:0] rd, output int fl,
                          output int ce, output int co);
        @(negedge clk);
        cyc_even = 0; cyc_odd = 0; first_lane = -1;
        cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = wd;
        region_sel = sel; wide_rdata = a ^ 16'hC0DE;
        #1;
        stall = 0;
        while (!cpu_ready && stall < 100) begin
            stall++;
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(negedge clk);
        fl = first_lane; ce = cyc_even; co = cyc_odd;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int          stall, fl, ce, co;
        logic [15:0] rd, expw;
        logic [7:0]  ev, od;
        bit          wr, sel;
        logic [15:0] a, wd;
        logic [15:0] rd_even, rd_odd;

        for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 37 + 11);
        rst = 1'b1; cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        cpu_wdata = '0; region_sel = 1'b0; wide_rdata = '0;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        chk(cpu_ready && !nb_rd && !nb_wr, "R1 in reset", {nb_rd, nb_wr, cpu_ready}, 3'b001);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready && !nb_rd && !nb_wr, "R1 after reset", {nb_rd, nb_wr, cpu_ready}, 3'b001);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            {wr, sel, a, wd} = VEC[v];
            access(wr, sel, a, wd, stall, rd, fl, ce, co);
            ev = a[7:0] & 8'hFE;
            od = a[7:0] | 8'h01;
            if (sel) begin
                chk(stall == EXP_STALL, wr ? "R6 write stall" : "R2 read stall", stall, EXP_STALL);
                chk(fl == 0, "R3 first lane even", fl, 0);
                chk(ce == BC, "R3 even byte cycles", ce, BC);
                chk(co == BC, "R3 odd byte cycles", co, BC);
            end else begin
                chk(stall == 0, "R7 no stall", stall, 0);
                chk(ce + co == 0, "R7 narrow bus quiet", ce + co, 0);
            end
            if (!wr) begin
                expw = sel ? {shadow[ev], shadow[od]} : (a ^ 16'hC0DE);
                chk(rd == expw,
                    !sel ? "R7 wide read data" : (a[0] ? "R5 odd-address read" : "R4 word assembly"),
                    rd, expw);
            end else if (sel) begin
                shadow[ev] = wd[15:8];
                shadow[od] = wd[7:0];
                chk(mem[ev] == wd[15:8], "R6 high byte at even address", mem[ev], wd[15:8]);
                chk(mem[od] == wd[7:0], "R6 low byte at odd address", mem[od], wd[7:0]);
            end else begin
                chk(mem[ev] == shadow[ev] && mem[od] == shadow[od],
                    "R7 write outside region ignored", {mem[ev], mem[od]},
                    {shadow[ev], shadow[od]});
            end
        end

        // R5: odd and even address of the same word read alike
        access(1'b0, 1'b1, 16'h0030, 16'h0, stall, rd_even, fl, ce, co);
        access(1'b0, 1'b1, 16'h0031, 16'h0, stall, rd_odd, fl, ce, co);
        chk(rd_even == rd_odd, "R5 bit0 ignored", rd_odd, rd_even);
        chk(rd_even == {shadow[8'h30], shadow[8'h31]}, "R4 big-endian order",
            rd_even, {shadow[8'h30], shadow[8'h31]});

        // R1: reset in the middle of a region read abandons it
        @(negedge clk);
        cpu_addr = 16'h0050; cpu_rd = 1'b1; region_sel = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        chk(cpu_ready && !nb_rd && !nb_wr, "R1 reset aborts transfer",
            {nb_rd, nb_wr, cpu_ready}, 3'b001);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 37 + 11);
        @(negedge clk);

        // Transfer after abort is complete
        access(1'b0, 1'b1, 16'h0050, 16'h0, stall, rd, fl, ce, co);
        chk(stall == EXP_STALL, "R2 stall after reset", stall, EXP_STALL);
        chk(rd == {shadow[8'h50], shadow[8'h51]}, "R4 read after reset",
            rd, {shadow[8'h50], shadow[8'h51]});

        // R8: strobes never overlapped
        chk(both_cnt == 0, "R8 exclusive strobes", both_cnt, 0);

        summary();
        $finish;
    end
endmodule